// File: doc/BRIEF.md
# Last-Level Cache Bank Steering Unit

This unit picks the last-level cache data bank that serves each request from a cluster of four cores. Each bank is paired with one cluster, and there are up to eight of each. A mode register selects one of three placement policies. In hashed-shared mode every line is spread over all working banks by a fold of its line address. In pinned-private mode a cluster uses only its own bank. In growable-partition mode a cluster owns a region that starts at its own bank and takes in ring neighbours as its allotted size grows. Lines flagged as used by more than one core go to the hashed placement instead.

A mask of fused-off banks removes banks from every policy. Each cluster has its own partition-size field. The bank choice is computed combinationally and captured in one output register. The register has a valid/ready handshake on both sides, so one accepted request yields one response on the next cycle. The outputs are the chosen bank number and a tag that says which policy placed the line.

Top module: `l3_bank_steer`

## Requirements
- R1: After reset the output holds no response (rspValid low, reqReady high) and the active policy is growable-partition.
- R2: A one-cycle write on modeWrEn loads modeWrData: 0 = hashed-shared, 1 = pinned-private, 2 = growable-partition. The code 3 is ignored and leaves the active policy unchanged. A write affects requests accepted after the write cycle.
- R3: In hashed-shared mode, the line address is split into 6-bit chunks starting at bit 0, with zero padding at the top, and the chunks are XORed together. The result modulo the number of enabled banks gives k, and the bank is the k-th enabled bank counted upward from bank 0. The tag is 0 (hashed). reqShared has no effect in this mode.
- R4: In pinned-private mode the bank is the cluster's own bank, numbered the same as reqCluster. If that bank is disabled, the bank is the first enabled bank in ring order. The tag is 1 (private) and reqShared has no effect.
- R5: In growable-partition mode with reqShared low, the cluster walks the ring in this order: own bank, +1, -1, +2, -2, and so on, modulo 8. The first S enabled banks met on this walk form the candidate list. Candidate number (reqLine[5:0] mod S) is chosen, and the tag is 2 (partition).
- R6: In growable-partition mode with reqShared high, the bank and tag follow the hashed rule of R3.
- R7: A disabled bank (bankDisable bit set) is never chosen while at least one bank is enabled. If all banks are disabled, the bank is 0.
- R8: Each cluster's size field S is partSize[4c+3:4c]. A value of 0 counts as 1, and a value above the number of enabled banks counts as that number.
- R9: A request is taken when reqValid and reqReady are both high, and its response appears on the following cycle. reqReady is high when the output is empty or is being taken. A response that is not taken keeps rspValid, rspBank and rspTag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 2 | Policy code to write |
| bankDisable | input | 8 | One bit per fused-off bank |
| partSize | input | 32 | Per-cluster partition size, 4 bits per cluster |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqCluster | input | 3 | Requesting cluster number |
| reqLine | input | 26 | Physical line address (64-byte offset removed) |
| reqShared | input | 1 | Line is shared between cores |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspBank | output | 3 | Chosen bank |
| rspTag | output | 2 | Placing policy: 0 hashed, 1 private, 2 partition |

## Verification
Several properties are checked on every cycle by the assertions:
- the reset-time policy;
- that a reserved mode code is ignored;
- that pinned-private requests reach their own bank;
- that shared lines in partition mode get the hashed tag;
- that a disabled bank is never picked;
- that a stalled response stays stable.

Other behaviour can only be shown by the bench's sweeps against its own arithmetic model: the exact hash fold and modulo, the ring-distance order of partition growth, the clamping of size fields, and the slicing of each cluster's own field. The sweeps cover every cluster, several disable masks and every size value from 0 to 9.

// File: rtl/l3steer_pkg.sv
package l3steer_pkg;

  typedef enum logic [1:0] {
    MODE_SHARED    = 2'd0,
    MODE_PRIVATE   = 2'd1,
    MODE_PARTITION = 2'd2,
    MODE_RSVD      = 2'd3
  } steerMode_e;

  typedef enum logic [1:0] {
    TAG_HASHED    = 2'd0,
    TAG_PRIVATE   = 2'd1,
    TAG_PARTITION = 2'd2,
    TAG_NONE      = 2'd3
  } placeTag_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       modeLoad;
    steerMode_e activeMode;
  } steerStrobe_t;

endpackage

// File: rtl/l3steer_ctrl.sv
module l3steer_ctrl
  import l3steer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeWrEn,
  input  logic [1:0]   modeWrData,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         rspReady,
  output logic         rspValid,
  output steerStrobe_t strobe
);

  steerMode_e modeQ;
  logic       validQ;
  logic       accept;
  logic       modeLoad;

  assign reqReady = !validQ || rspReady;
  assign accept   = reqValid && reqReady;
  assign modeLoad = modeWrEn && (modeWrData != MODE_RSVD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_PARTITION;
      validQ <= 1'b0;
    end else begin
      if (modeLoad) modeQ <= steerMode_e'(modeWrData);
      if (accept) validQ <= 1'b1;
      else if (rspReady) validQ <= 1'b0;
    end
  end

  assign rspValid          = validQ;
  assign strobe.capture    = accept;
  assign strobe.modeLoad   = modeLoad;
  assign strobe.activeMode = modeQ;

endmodule

// File: rtl/l3steer_datapath.sv
module l3steer_datapath
  import l3steer_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int LINE_W    = 26,
  parameter int HASH_W    = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int SIZE_W   = $clog2(NUM_BANKS) + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  steerStrobe_t                strobe,
  input  logic [NUM_BANKS-1:0]        bankDisable,
  input  logic [NUM_BANKS*SIZE_W-1:0] partSize,
  input  logic [BANK_W-1:0]           reqCluster,
  input  logic [LINE_W-1:0]           reqLine,
  input  logic                        reqShared,
  output logic [BANK_W-1:0]           rspBank,
  output logic [1:0]                  rspTag
);

  localparam int NCHUNK = (LINE_W + HASH_W - 1) / HASH_W;

  logic [NUM_BANKS-1:0]       enabled;
  logic [SIZE_W-1:0]          nEnabled;
  logic [NCHUNK*HASH_W-1:0]   padLine;
  logic [HASH_W-1:0]          fold;
  logic [HASH_W-1:0]          hashRem;
  logic [HASH_W-1:0]          hashSeen;
  logic [BANK_W-1:0]          hashBank;
  logic [SIZE_W-1:0]          sizeRaw;
  logic [SIZE_W-1:0]          sizeEff;
  logic [HASH_W-1:0]          selIdx;
  logic [HASH_W-1:0]          taken;
  logic [BANK_W-1:0]          localBank;
  logic                       useHash;
  placeTag_e                  nextTag;
  logic [BANK_W-1:0]          nextBank;
  logic [BANK_W-1:0]          bankQ;
  placeTag_e                  tagQ;

  function automatic int ringOffset(input int p);
    if (p == 0) return 0;
    else if ((p % 2) == 1) return (p + 1) / 2;
    else return -(p / 2);
  endfunction

  assign enabled = ~bankDisable;
  assign padLine = (NCHUNK*HASH_W)'(reqLine);

  always_comb begin
    nEnabled = '0;
    for (int b = 0; b < NUM_BANKS; b++) nEnabled = nEnabled + SIZE_W'(enabled[b]);
  end

  // address fold for the hashed placement
  always_comb begin
    fold = '0;
    for (int i = 0; i < NCHUNK; i++) fold = fold ^ padLine[i*HASH_W +: HASH_W];
  end

  assign hashRem = (nEnabled == '0) ? '0 : (fold % HASH_W'(nEnabled));

  always_comb begin
    hashBank = '0;
    hashSeen = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (enabled[b]) begin
        if (hashSeen == hashRem) hashBank = BANK_W'(b);
        hashSeen = hashSeen + HASH_W'(1);
      end
    end
  end

  // partition width: private mode is a partition of one bank
  assign sizeRaw = partSize[int'(reqCluster)*SIZE_W +: SIZE_W];

  always_comb begin
    if (strobe.activeMode == MODE_PRIVATE) sizeEff = SIZE_W'(1);
    else if (sizeRaw == '0) sizeEff = SIZE_W'(1);
    else sizeEff = sizeRaw;
    if (sizeEff > nEnabled) sizeEff = nEnabled;
  end

  assign selIdx = (sizeEff == '0) ? '0 : (reqLine[HASH_W-1:0] % HASH_W'(sizeEff));

  // ring walk in order of growing distance from the own bank
  always_comb begin
    localBank = '0;
    taken     = '0;
    for (int p = 0; p < NUM_BANKS; p++) begin
      int slot;
      slot = (int'(reqCluster) + 2*NUM_BANKS + ringOffset(p)) % NUM_BANKS;
      if (enabled[BANK_W'(slot)]) begin
        if (taken == selIdx) localBank = BANK_W'(slot);
        taken = taken + HASH_W'(1);
      end
    end
  end

  always_comb begin
    useHash = (strobe.activeMode == MODE_SHARED) ||
              ((strobe.activeMode == MODE_PARTITION) && reqShared);
    if (useHash) begin
      nextBank = hashBank;
      nextTag  = TAG_HASHED;
    end else begin
      nextBank = localBank;
      nextTag  = (strobe.activeMode == MODE_PRIVATE) ? TAG_PRIVATE : TAG_PARTITION;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= '0;
      tagQ  <= TAG_HASHED;
    end else if (strobe.capture) begin
      bankQ <= nextBank;
      tagQ  <= nextTag;
    end
  end

  assign rspBank = bankQ;
  assign rspTag  = tagQ;

endmodule

// File: rtl/l3_bank_steer.sv
module l3_bank_steer
  import l3steer_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int LINE_W    = 26,
  parameter int HASH_W    = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int SIZE_W   = $clog2(NUM_BANKS) + 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        modeWrEn,
  input  logic [1:0]                  modeWrData,
  input  logic [NUM_BANKS-1:0]        bankDisable,
  input  logic [NUM_BANKS*SIZE_W-1:0] partSize,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [BANK_W-1:0]           reqCluster,
  input  logic [LINE_W-1:0]           reqLine,
  input  logic                        reqShared,
  output logic                        rspValid,
  input  logic                        rspReady,
  output logic [BANK_W-1:0]           rspBank,
  output logic [1:0]                  rspTag
);

  steerStrobe_t strobe;
  logic [1:0]   activeMode;

  assign activeMode = strobe.activeMode;

  l3steer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .rspReady   (rspReady),
    .rspValid   (rspValid),
    .strobe     (strobe)
  );

  l3steer_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .LINE_W    (LINE_W),
    .HASH_W    (HASH_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .bankDisable (bankDisable),
    .partSize    (partSize),
    .reqCluster  (reqCluster),
    .reqLine     (reqLine),
    .reqShared   (reqShared),
    .rspBank     (rspBank),
    .rspTag      (rspTag)
  );

endmodule

// File: rtl/l3steer_checker.sv
module l3steer_checker #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 modeWrEn,
  input logic [1:0]           modeWrData,
  input logic [NUM_BANKS-1:0] bankDisable,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [BANK_W-1:0]    reqCluster,
  input logic                 reqShared,
  input logic                 rspValid,
  input logic                 rspReady,
  input logic [BANK_W-1:0]    rspBank,
  input logic [1:0]           rspTag,
  input logic [1:0]           activeMode
);

  logic [NUM_BANKS-1:0] disQ;
  logic                 anyEnQ;
  logic                 accept;

  assign accept = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      disQ   <= '0;
      anyEnQ <= 1'b0;
    end else begin
      disQ   <= bankDisable;
      anyEnQ <= accept && (|(~bankDisable));
    end
  end

  assert_reset_mode_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (activeMode == 2'd2) && !rspValid);

  assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && modeWrData == 2'd3) |=> $stable(activeMode));

  assert_private_own_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && activeMode == 2'd1 && !bankDisable[reqCluster])
      |=> (rspTag == 2'd1) && (rspBank == $past(reqCluster)));

  assert_shared_hashed_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && activeMode == 2'd2 && reqShared) |=> (rspTag == 2'd0));

  assert_enabled_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    anyEnQ |-> !disQ[rspBank]);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid && $stable(rspBank) && $stable(rspTag));

  assert_response_next_R9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);

endmodule

bind l3_bank_steer l3steer_checker #(.NUM_BANKS(NUM_BANKS)) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .modeWrEn    (modeWrEn),
  .modeWrData  (modeWrData),
  .bankDisable (bankDisable),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqCluster  (reqCluster),
  .reqShared   (reqShared),
  .rspValid    (rspValid),
  .rspReady    (rspReady),
  .rspBank     (rspBank),
  .rspTag      (rspTag),
  .activeMode  (activeMode)
);

// File: tb/test_l3_bank_steer.sv
`timescale 1ns/1ps
module test_l3_bank_steer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWrEn = 1'b0;
  logic [1:0]  modeWrData = 2'd0;
  logic [7:0]  bankDisable = 8'h00;
  logic [31:0] partSize = 32'h0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqCluster = 3'd0;
  logic [25:0] reqLine = 26'd0;
  logic        reqShared = 1'b0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic [2:0]  rspBank;
  logic [1:0]  rspTag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  l3_bank_steer i_l3_bank_steer (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .bankDisable(bankDisable), .partSize(partSize), .reqValid(reqValid),
    .reqReady(reqReady), .reqCluster(reqCluster), .reqLine(reqLine),
    .reqShared(reqShared), .rspValid(rspValid), .rspReady(rspReady),
    .rspBank(rspBank), .rspTag(rspTag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int enCount(input logic [7:0] dis);
    int n = 0;
    for (int b = 0; b < 8; b++) if (!dis[b]) n++;
    return n;
  endfunction

  // R3: fold bit b into position b mod 6, then pick the k-th enabled bank
  function automatic int modelHash(input logic [25:0] a, input logic [7:0] dis);
    int f = 0;
    int n = enCount(dis);
    int k;
    int seen = 0;
    for (int b = 0; b < 26; b++) if (a[b]) f = f ^ (1 << (b % 6));
    if (n == 0) return 0;
    k = f % n;
    for (int b = 0; b < 8; b++) begin
      if (!dis[b]) begin
        if (seen == k) return b;
        seen++;
      end
    end
    return 0;
  endfunction

  // R5/R8: candidate list by ring distance, clockwise neighbour first
  function automatic int modelLocal(input int c, input logic [25:0] a,
                                    input logic [7:0] dis, input int size);
    int n = enCount(dis);
    int eff = (size == 0) ? 1 : size;
    int sel;
    int got = 0;
    if (eff > n) eff = n;
    if (eff == 0) return 0;
    sel = int'(a[5:0]) % eff;
    for (int d = 0; d <= 4; d++) begin
      for (int s = 0; s < 2; s++) begin
        int bk;
        if (d == 0 && s == 1) continue;
        if (d == 4 && s == 1) continue;
        bk = (s == 0) ? (c + d) % 8 : (c + 8 - d) % 8;
        if (!dis[bk]) begin
          if (got == sel) return bk;
          got++;
        end
      end
    end
    return 0;
  endfunction

  task automatic writeMode(input logic [1:0] m);
    modeWrEn = 1'b1;
    modeWrData = m;
    @(negedge clk);
    modeWrEn = 1'b0;
  endtask

  task automatic issue(input int c, input logic [25:0] a, input bit sh);
    reqCluster = 3'(c);
    reqLine = a;
    reqShared = sh;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect2(input string req, input int bank, input int tag);
    chk({req, " valid"}, int'(rspValid), 1);
    chk({req, " bank"}, int'(rspBank), bank);
    chk({req, " tag"}, int'(rspTag), tag);
  endtask

  function automatic logic [25:0] addrOf(input int i);
    logic [31:0] x = 32'h9E3779B1 * (i + 7);
    return x[31:6] ^ {x[11:0], x[25:12]};
  endfunction

  logic [7:0] masks [6] = '{8'h00, 8'h05, 8'h80, 8'h7E, 8'h3C, 8'hFF};

  initial begin
    #(200_000 * 5);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: empty output after reset, default policy is partition
    chk("R1 rspValid", int'(rspValid), 0);
    chk("R1 reqReady", int'(reqReady), 1);
    partSize = {8{4'd1}};
    issue(3, 26'h0000040, 1'b0);
    expect2("R1 default partition", 3, 2);

    // R3: hashed-shared sweep, reqShared varied
    writeMode(2'd0);
    for (int m = 0; m < 6; m++) begin
      bankDisable = masks[m];
      for (int c = 0; c < 8; c++) begin
        for (int i = 0; i < 6; i++) begin
          logic [25:0] a = addrOf(i + c * 11 + m * 97);
          issue(c, a, 1'(i & 1));
          expect2("R3 hashed", modelHash(a, masks[m]), 0);
          if (masks[m] != 8'hFF) chk("R7 not disabled", int'(masks[m][rspBank]), 0);
        end
      end
    end

    // R4: pinned-private
    writeMode(2'd1);
    partSize = {8{4'd6}};
    for (int m = 0; m < 6; m++) begin
      bankDisable = masks[m];
      for (int c = 0; c < 8; c++) begin
        for (int i = 0; i < 4; i++) begin
          logic [25:0] a = addrOf(i + c * 5 + m * 31);
          issue(c, a, 1'(i & 1));
          expect2("R4 private", modelLocal(c, a, masks[m], 1), 1);
          if (masks[m] != 8'hFF) chk("R7 not disabled", int'(masks[m][rspBank]), 0);
        end
      end
    end

    // R2: reserved code ignored, then partition restored
    writeMode(2'd3);
    bankDisable = 8'h00;
    issue(2, 26'h0001234, 1'b0);
    expect2("R2 reserved ignored", 2, 1);
    writeMode(2'd2);

    // R5/R8: partition sweep over sizes 0..9, own field only
    for (int m = 0; m < 6; m++) begin
      bankDisable = masks[m];
      for (int c = 0; c < 8; c++) begin
        for (int s = 0; s < 10; s++) begin
          partSize = {8{4'd15}};
          partSize[c*4 +: 4] = 4'(s);
          for (int i = 0; i < 3; i++) begin
            logic [25:0] a = addrOf(i + s * 3 + c * 17 + m * 131);
            issue(c, a, 1'b0);
            expect2("R5 R8 partition", modelLocal(c, a, masks[m], s), 2);
            if (masks[m] != 8'hFF) chk("R7 not disabled", int'(masks[m][rspBank]), 0);
          end
          // R6: shared line leaves the partition
          begin
            logic [25:0] a = addrOf(s + c * 3 + m * 7 + 500);
            issue(c, a, 1'b1);
            expect2("R6 shared forced hash", modelHash(a, masks[m]), 0);
          end
        end
      end
    end

    // R7: all banks fused off
    bankDisable = 8'hFF;
    issue(5, 26'h3ABCDEF, 1'b0);
    chk("R7 all disabled bank", int'(rspBank), 0);

    // R9: stall holds the response, next request waits
    bankDisable = 8'h00;
    writeMode(2'd1);
    rspReady = 1'b0;
    issue(1, 26'h0000100, 1'b0);
    chk("R9 valid after accept", int'(rspValid), 1);
    chk("R9 ready low when full", int'(reqReady), 0);
    reqCluster = 3'd5;
    reqValid = 1'b1;
    @(negedge clk);
    chk("R9 held bank", int'(rspBank), 1);
    chk("R9 held valid", int'(rspValid), 1);
    rspReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 next bank", int'(rspBank), 5);
    @(negedge clk);
    chk("R9 drained", int'(rspValid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule